// File: doc/BRIEF.md
# Rectangular Pixel Block Mover

This engine moves a rectangle of 16-bit pixels between a 32-bit host word port and a pixel memory of 1024 columns by 512 rows. A transfer is opened with two words: a position word that gives the top-left corner and a size word that gives the width and height in pixels. Every host word carries two pixels, and the engine walks them through the rectangle row by row.

The walk state has three parts: the current row, the rows still to go, and the pixel offset inside the current row. It persists between host words, so the data may arrive in bursts of any length with gaps of any length, and a burst may stop in the middle of a row. Toward the memory the engine issues one registered address per pixel lane, with a write enable in write direction or a read enable in read direction. It reports busy to the command framer, which must route host words to the engine rather than decode them while busy is high. In read direction a status flag announces that image data is waiting, and each read request returns one packed word.

Top module: `rect_xfer_engine`

## Requirements
- R1: On `start`, x is `pos_word[9:0]`, y is `pos_word[24:16]`, width is `size_word[15:0]`, height is `size_word[31:16]`, the offset is cleared, and `busy` is high in the following cycle whenever the height is nonzero.
- R2: Pixel lane 0 carries bits 15:0 of a host word and is the earlier pixel. Lane 1 carries bits 31:16 and is the next pixel.
- R3: A pixel's memory address is (y*1024 + x + offset) modulo 2^19, driven on the lane's 19-bit slice of `mem_addr` one cycle after the host word is taken.
- R4: When a pixel is the last one of its row (offset+1 >= width), the offset returns to 0, y advances modulo 512 and the remaining height drops by one. Otherwise the offset advances by one.
- R5: `busy` equals (remaining height != 0). When the final pixel of a transfer falls in lane 0, lane 1 raises no enable. When height reaches zero, `busy` falls in the same cycle as the last enable appears.
- R6: A gap in `wr_valid` or `rd_req` leaves row, height and offset unchanged, so the next word continues from the exact next pixel even in the middle of a row.
- R7: In read direction each `rd_req` raises `mem_re` for the live lanes one cycle later. `rd_valid` pulses three edges after the request, with `rd_data` = {lane 1 pixel, lane 0 pixel}, and a lane that has no pixel reads as 0.
- R8: `img_ready` is set by a read-direction start with nonzero height. It is cleared by a write-direction start, and by the request that consumes the final pixel of a read transfer.
- R9: An `rd_req` when no read transfer is active still pulses `rd_valid` with the same latency, returns the previously latched `rd_data` unchanged, and raises no `mem_re`.
- R10: `wr_valid` while idle or in read direction raises no `mem_we` and does not move the walk state.
- R11: A `start` during an active transfer discards the old walk state, and the next word lands at the new rectangle's first pixel.
- R12: After reset `busy`, `img_ready`, `rd_valid`, `mem_we` and `mem_re` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Open a transfer using `pos_word`, `size_word` and `dir_read` |
| dir_read | input | 1 | 1 = memory to host, 0 = host to memory |
| pos_word | input | 32 | Corner: x in bits 9:0, y in bits 24:16 |
| size_word | input | 32 | Width in bits 15:0, height in bits 31:16 |
| wr_valid | input | 1 | Host word present on `wr_data` |
| wr_data | input | 32 | Two pixels, low half first |
| rd_req | input | 1 | Host asks for one packed word |
| rd_data | output | 32 | Latched packed read word |
| rd_valid | output | 1 | One-cycle pulse marking a read answer |
| busy | output | 1 | Transfer has rows remaining |
| img_ready | output | 1 | Read data waiting for the host |
| mem_addr | output | 38 | Two 19-bit pixel addresses, lane 0 in the low slice |
| mem_we | output | 2 | Per-lane write enable |
| mem_wdata | output | 32 | Per-lane write pixels |
| mem_re | output | 2 | Per-lane read enable |
| mem_q | input | 32 | Per-lane read pixels, one cycle after `mem_re` |

## Verification
A wrong row, offset or height register shows on the very next enabled address. It surfaces within one word when a row boundary or the 1023/0 column seam is crossed, and within a row's worth of words otherwise. The scoreboard compares every address and pixel the engine emits against the rectangle walked independently, so a miscounted height appears as a missing or extra enable at the tail of the transfer. Mishandled burst gaps and restarts appear as a shifted address on the first word after the gap. Read-side faults show one packed word later as wrong lane order, stale data, or a dead lane that is not zero.

// File: rtl/rx_pkg.sv
package rx_pkg;
  typedef enum logic {DIR_WRITE = 1'b0, DIR_READ = 1'b1} xfer_dir_e;
endpackage

// File: rtl/rx_geom.sv
module rx_geom #(
  parameter int XB = 10,
  parameter int YB = 9,
  parameter int LW = 16
) (
  input  logic [31:0]   pos_word,
  input  logic [31:0]   size_word,
  output logic [XB-1:0] x_o,
  output logic [YB-1:0] y_o,
  output logic [LW-1:0] w_o,
  output logic [LW-1:0] h_o
);
  // corner and extent fields of the two opening words
  assign x_o = pos_word[XB-1:0];
  assign y_o = pos_word[16 +: YB];
  assign w_o = size_word[LW-1:0];
  assign h_o = size_word[16 +: LW];
endmodule

// File: rtl/rx_step.sv
module rx_step #(
  parameter int XB = 10,
  parameter int YB = 9,
  parameter int LW = 16,
  parameter int AW = XB + YB
) (
  input  logic [XB-1:0] x_i,
  input  logic [LW-1:0] w_i,
  input  logic [YB-1:0] y_i,
  input  logic [LW-1:0] h_i,
  input  logic [LW-1:0] off_i,
  output logic [AW-1:0] addr_o,
  output logic          live_o,
  output logic [YB-1:0] y_o,
  output logic [LW-1:0] h_o,
  output logic [LW-1:0] off_o
);
  logic [AW-1:0] base;
  logic [LW:0]   off_inc;
  logic          row_end;

  assign base    = {y_i, {XB{1'b0}}};
  assign addr_o  = base + AW'(x_i) + AW'(off_i);
  assign live_o  = (h_i != '0);
  assign off_inc = {1'b0, off_i} + (LW+1)'(1);
  assign row_end = off_inc >= {1'b0, w_i};

  always_comb begin
    y_o   = y_i;
    h_o   = h_i;
    off_o = off_i;
    if (live_o) begin
      if (row_end) begin
        off_o = '0;
        y_o   = y_i + YB'(1);
        h_o   = h_i - LW'(1);
      end else begin
        off_o = off_inc[LW-1:0];
      end
    end
  end
endmodule

// File: rtl/rx_rdmerge.sv
module rx_rdmerge #(
  parameter int PIX   = 16,
  parameter int LANES = 2,
  localparam int WW   = PIX * LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic [LANES-1:0] lane_i,
  input  logic [WW-1:0]    q_i,
  output logic [WW-1:0]    data_o,
  output logic             valid_o
);
  logic             req_q;
  logic [LANES-1:0] lane_q;
  logic [WW-1:0]    merged;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign merged[i*PIX +: PIX] = lane_q[i] ? q_i[i*PIX +: PIX] : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q   <= 1'b0;
      lane_q  <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      req_q   <= req_i;
      lane_q  <= lane_i;
      valid_o <= req_q;
      if (req_q && (lane_q != '0)) data_o <= merged;
    end
  end

  // R9: an answer with no live lane keeps the previous word
  a_r9_stale_word_kept: assert property (@(posedge clk) disable iff (rst)
    (req_q && lane_q == '0) |=> $stable(data_o));
endmodule

// File: rtl/rect_xfer_engine.sv
module rect_xfer_engine
  import rx_pkg::*;
#(
  parameter int XB    = 10,
  parameter int YB    = 9,
  parameter int LW    = 16,
  parameter int PIX   = 16,
  parameter int LANES = 2,
  localparam int AW   = XB + YB,
  localparam int WW   = PIX * LANES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               dir_read,
  input  logic [31:0]        pos_word,
  input  logic [31:0]        size_word,
  input  logic               wr_valid,
  input  logic [WW-1:0]      wr_data,
  input  logic               rd_req,
  output logic [WW-1:0]      rd_data,
  output logic               rd_valid,
  output logic               busy,
  output logic               img_ready,
  output logic [LANES*AW-1:0] mem_addr,
  output logic [LANES-1:0]   mem_we,
  output logic [WW-1:0]      mem_wdata,
  output logic [LANES-1:0]   mem_re,
  input  logic [WW-1:0]      mem_q
);
  xfer_dir_e     dir_q;
  logic [XB-1:0] x_q;
  logic [LW-1:0] w_q;
  logic          rd_s1;

  logic [XB-1:0] g_x;
  logic [YB-1:0] g_y;
  logic [LW-1:0] g_w, g_h;

  // walk chain: entry 0 is the stored state, entry i+1 follows lane i
  logic [YB-1:0]    cy   [LANES+1];
  logic [LW-1:0]    ch   [LANES+1];
  logic [LW-1:0]    co   [LANES+1];
  logic [AW-1:0]    laddr[LANES];
  logic [LANES-1:0] llive;

  logic take_wr, take_rd;

  rx_geom #(.XB(XB), .YB(YB), .LW(LW)) u_geom (
    .pos_word(pos_word), .size_word(size_word),
    .x_o(g_x), .y_o(g_y), .w_o(g_w), .h_o(g_h)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_step
    rx_step #(.XB(XB), .YB(YB), .LW(LW), .AW(AW)) u_step (
      .x_i(x_q), .w_i(w_q),
      .y_i(cy[i]), .h_i(ch[i]), .off_i(co[i]),
      .addr_o(laddr[i]), .live_o(llive[i]),
      .y_o(cy[i+1]), .h_o(ch[i+1]), .off_o(co[i+1])
    );
  end

  assign busy    = (ch[0] != '0);
  assign take_wr = wr_valid && busy && (dir_q == DIR_WRITE);
  assign take_rd = rd_req   && busy && (dir_q == DIR_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q     <= DIR_WRITE;
      x_q       <= '0;
      w_q       <= '0;
      cy[0]     <= '0;
      ch[0]     <= '0;
      co[0]     <= '0;
      img_ready <= 1'b0;
      mem_we    <= '0;
      mem_re    <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rd_s1     <= 1'b0;
    end else begin
      mem_we <= '0;
      mem_re <= '0;
      rd_s1  <= rd_req;
      if (start) begin
        dir_q     <= dir_read ? DIR_READ : DIR_WRITE;
        x_q       <= g_x;
        w_q       <= g_w;
        cy[0]     <= g_y;
        ch[0]     <= g_h;
        co[0]     <= '0;
        img_ready <= dir_read && (g_h != '0);
      end else if (take_wr || take_rd) begin
        cy[0] <= cy[LANES];
        ch[0] <= ch[LANES];
        co[0] <= co[LANES];
        for (int i = 0; i < LANES; i++) mem_addr[i*AW +: AW] <= laddr[i];
        mem_wdata <= wr_data;
        if (take_wr) mem_we <= llive;
        if (take_rd) mem_re <= llive;
        if (take_rd && ch[LANES] == '0) img_ready <= 1'b0;
      end
    end
  end

  rx_rdmerge #(.PIX(PIX), .LANES(LANES)) u_merge (
    .clk(clk), .rst(rst), .req_i(rd_s1), .lane_i(mem_re),
    .q_i(mem_q), .data_o(rd_data), .valid_o(rd_valid)
  );

  // R10: no write enable while the walk runs in read direction
  a_r10_no_write_in_read: assert property (@(posedge clk) disable iff (rst)
    (dir_q == DIR_READ) |-> (mem_we == '0));

  // R4: remaining height never grows except by a new start
  a_r4_height_shrinks: assert property (@(posedge clk) disable iff (rst)
    (busy && !start) |=> (ch[0] <= $past(ch[0])));

  // R4: the stored offset stays inside the row
  a_r4_offset_in_row: assert property (@(posedge clk) disable iff (rst)
    (busy && w_q != '0) |-> (co[0] < w_q));

  // R6: without start or data the walk state is frozen
  a_r6_gap_holds_state: assert property (@(posedge clk) disable iff (rst)
    (!start && !wr_valid && !rd_req) |=> ($stable(ch[0]) && $stable(co[0]) && $stable(cy[0])));

  // R5: a higher lane is only enabled together with all lower lanes
  for (genvar i = 1; i < LANES; i++) begin : g_chk
    a_r5_lane_order: assert property (@(posedge clk) disable iff (rst)
      (mem_we[i] || mem_re[i]) |-> ((mem_we[i-1] && mem_we[i]) || (mem_re[i-1] && mem_re[i])));
  end
endmodule

// File: tb/sim_rect_xfer_engine.sv
module sim_rect_xfer_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        start = 0, dir_read = 0, wr_valid = 0, rd_req = 0;
  logic [31:0] pos_word = 0, size_word = 0, wr_data = 0;
  logic [31:0] rd_data, mem_wdata, mem_q;
  logic        rd_valid, busy, img_ready;
  logic [37:0] mem_addr;
  logic [1:0]  mem_we, mem_re;

  rect_xfer_engine u0 (
    .clk(clk), .rst(rst), .start(start), .dir_read(dir_read),
    .pos_word(pos_word), .size_word(size_word),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req),
    .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .img_ready(img_ready),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_re(mem_re), .mem_q(mem_q)
  );

  int checks = 0, errors = 0;

  // sparse pixel memory driven by the design, and the bench's own image
  logic [15:0] mem  [int];
  logic [15:0] refm [int];
  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      int a;
      a = int'(mem_addr[i*19 +: 19]);
      if (mem_we[i]) mem[a] = mem_wdata[i*16 +: 16];
      if (mem_re[i]) mem_q[i*16 +: 16] <= mem.exists(a) ? mem[a] : 16'h0;
    end
  end

  // scoreboard queues
  int          q_addr[$];
  logic [15:0] q_pix[$];
  logic [31:0] q_rd[$];
  logic [31:0] last_rd = 0;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // monitor: pops and compares as results appear
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = 0; i < 2; i++) begin
        if (mem_we[i]) begin
          if (q_addr.size() == 0) chk("R10 unexpected write enable", {30'd0, mem_we}, 32'd0);
          else begin
            chk("R3/R4/R6 write address", {13'd0, mem_addr[i*19 +: 19]}, q_addr.pop_front());
            chk("R2 lane pixel", {16'd0, mem_wdata[i*16 +: 16]}, {16'd0, q_pix.pop_front()});
          end
        end
      end
      if (rd_valid) begin
        if (q_rd.size() == 0) chk("R9 unexpected read answer", 32'd1, 32'd0);
        else chk("R7/R9 read word", rd_data, q_rd.pop_front());
      end
    end
  end

  // bench walk model
  int bx, by, bw, bh, bk, btot;
  logic bread;

  function automatic int paddr(int k);
    int row, col;
    row = k / bw;
    col = k % bw;
    return (((by + row) % 512) * 1024 + bx + col) % 524288;
  endfunction

  task automatic open_xfer(bit rd, int x, int y, int w, int h);
    @(negedge clk);
    start = 1; dir_read = rd;
    pos_word  = {7'h55, 9'(y), 6'h2a, 10'(x)};
    size_word = {16'(h), 16'(w)};
    bx = x; by = y; bw = w; bh = h; bk = 0; btot = w * h; bread = rd;
    @(negedge clk);
    start = 0;
  endtask

  task automatic send_word(logic [31:0] d);
    wr_valid = 1; wr_data = d;
    if (!bread) begin
      for (int i = 0; i < 2; i++) begin
        if (bk < btot) begin
          q_addr.push_back(paddr(bk));
          q_pix.push_back(d[i*16 +: 16]);
          refm[paddr(bk)] = d[i*16 +: 16];
          bk++;
        end
      end
    end
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic ask_word();
    logic [31:0] e;
    e = last_rd;
    if (bread && bk < btot) begin
      e = 0;
      for (int i = 0; i < 2; i++) begin
        if (bk < btot) begin
          e[i*16 +: 16] = refm.exists(paddr(bk)) ? refm[paddr(bk)] : 16'h0;
          bk++;
        end
      end
    end
    last_rd = e;
    q_rd.push_back(e);
    rd_req = 1;
    @(negedge clk);
    rd_req = 0;
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R12 reset state
    chk("R12 busy", {31'd0, busy}, 0);
    chk("R12 img_ready", {31'd0, img_ready}, 0);
    chk("R12 rd_valid", {31'd0, rd_valid}, 0);
    chk("R12 mem_we/mem_re", {28'd0, mem_we, mem_re}, 0);
    rst = 0;

    // R10 write while idle: must raise nothing
    bread = 1'b1; btot = 0; bk = 0;
    wr_valid = 1; wr_data = 32'hdead_beef; @(negedge clk); wr_valid = 0;
    repeat (2) @(negedge clk);

    // write across the column seam and the row wrap, in two bursts
    open_xfer(0, 1020, 510, 5, 3);
    chk("R1 busy after start", {31'd0, busy}, 1);
    chk("R8 img_ready low for write", {31'd0, img_ready}, 0);
    for (int n = 0; n < 3; n++) send_word(32'h1000_0001 * (n + 1) + 32'h0a0b_0c0d);
    repeat (4) @(negedge clk);
    chk("R6 busy held across gap", {31'd0, busy}, 1);
    for (int n = 3; n < 7; n++) send_word(32'h1000_0001 * (n + 1) + 32'h0a0b_0c0d);
    chk("R5 busy before final word", {31'd0, busy}, 1);
    send_word(32'h7777_5555);  // lane 1 of this word has no pixel
    chk("R5 busy falls after final pixel", {31'd0, busy}, 0);
    send_word(32'h1234_5678);  // R10 extra word after the end
    repeat (3) @(negedge clk);

    // read the same rectangle back with uneven gaps
    open_xfer(1, 1020, 510, 5, 3);
    chk("R8 img_ready after read start", {31'd0, img_ready}, 1);
    wr_valid = 1; wr_data = 32'hffff_ffff; @(negedge clk); wr_valid = 0; // R10 ignored in read
    for (int n = 0; n < 8; n++) begin
      ask_word();
      repeat (n % 3) @(negedge clk);
    end
    chk("R8 img_ready cleared at end", {31'd0, img_ready}, 0);
    chk("R5 busy low after read", {31'd0, busy}, 0);
    repeat (4) @(negedge clk);
    ask_word();  // R9 idle read returns previous word
    repeat (4) @(negedge clk);
    chk("R9 rd_data unchanged", rd_data, last_rd);
    chk("R9 no read enable", {30'd0, mem_re}, 0);

    // R11 restart mid-transfer
    open_xfer(0, 3, 7, 4, 2);
    send_word(32'haaaa_bbbb);
    open_xfer(0, 100, 0, 3, 1);
    chk("R11 busy after restart", {31'd0, busy}, 1);
    send_word(32'h0101_0202);
    send_word(32'h0303_0404);
    chk("R11 restarted transfer done", {31'd0, busy}, 0);

    // read start then write start clears the flag (R8)
    open_xfer(1, 0, 0, 2, 2);
    chk("R8 read start sets flag", {31'd0, img_ready}, 1);
    open_xfer(0, 0, 0, 2, 1);
    chk("R8 write start clears flag", {31'd0, img_ready}, 0);
    send_word(32'h9999_8888);
    repeat (6) @(negedge clk);

    chk("R3 write queue drained", q_addr.size(), 0);
    chk("R7 read queue drained", q_rd.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule